// File: doc/BRIEF.md
# GPIO Unit with Grouped Interrupts

This block is a 32-pin general-purpose I/O unit with a small register file and four interrupt outputs. Each interrupt output serves one group of eight pins and feeds a chip-level interrupt cause unit. Software sets each pin's direction. It can invert an input's sense through a polarity bit. It drives output pins through the value register or through two aliases that set or clear bits in one write. A rising change on a conditioned input latches a sticky cause bit. If that pin is unmasked, the rising change also raises its group's interrupt.

A group interrupt clears in one of two ways, chosen by a single mode bit. In edge mode, software clears the interrupt by writing the cause register so that none of the group's cause bits are left set. In level mode, the interrupt drops by itself once every value bit of the group has returned to 0. Each input passes through a two-flop synchroniser. Edges are detected on the synchronised, polarity-corrected level.

Top module: `gpio_grp`

## Requirements
- R1: After reset, the direction, polarity, value, cause and mask registers all read 0, every group interrupt is low, and level mode is off.
- R2: A write to the value register (word address 2) updates only the bits whose direction bit is 1 (output). An input bit keeps following its conditioned input.
- R3: A write to the set alias (address 3) ORs in the written bits masked by direction. A write to the clear alias (address 4) clears those bits. Both aliases read as 0.
- R4: Input bit i of the value register shows pin i XOR polarity bit i (polarity at address 1). The value appears at the third rising clock edge after the pin changes.
- R5: A 0-to-1 change of a conditioned input pin sets its cause bit (address 5). A 1-to-0 change leaves the cause bit set.
- R6: A rise on pin i with mask bit i set raises group interrupt i/8 (irq_grp_o[i/8]) at the same edge that sets the cause bit. With the mask bit clear, only the cause bit is set.
- R7: In edge mode, a cause write that leaves all eight of a group's cause bits at 0 drops that group's interrupt. A write that leaves any of them set, or a return of the input to 0, keeps it raised.
- R8: In level mode, a group's interrupt drops one edge after all of that group's value bits are 0. Cause writes do not drop it.
- R9: The control register (address 8) holds the level-mode bit at bit 10. A read returns 0x11ff0000 OR'd with that bit, and all other written bits are ignored.
- R10: Addresses 6 and 7 reach the same 32-bit mask register, for both reads and writes.
- R11: When a rise and a cause write land on the same edge, the rise's cause bit is set on top of the written value. The group interrupt is also set, even if the write would have cleared it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from address |
| pin_i | input | 32 | Raw pin levels, asynchronous |
| pin_out_o | output | 32 | Value register, driven to pads |
| pin_oe_o | output | 32 | Direction register, 1 = drive |
| irq_grp_o | output | 4 | Interrupt per group of eight pins |

## Verification
A corrupted value bit shows up in two places: a value read, and the next level-mode interrupt decision, which comes one edge after the value changes. A corrupted edge history creates or loses a cause bit at the third edge after a pin change. The bench therefore samples reads and interrupts at exact edge counts. A wrong interrupt-clear term shows on irq_grp_o at the edge right after the cause write or the value change that should clear it. The bench checks both the cycle just before and the cycle just after that edge in level mode.

// File: rtl/gpio_grp_pkg.sv
package gpio_grp_pkg;
  localparam int unsigned ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_DIR   = 4'd0,
    A_POL   = 4'd1,
    A_VAL   = 4'd2,
    A_SET   = 4'd3,
    A_CLR   = 4'd4,
    A_CAUSE = 4'd5,
    A_MASK0 = 4'd6,
    A_MASK1 = 4'd7,
    A_CTRL  = 4'd8
  } reg_addr_e;
endpackage

// File: rtl/gpio_grp_sync.sv
module gpio_grp_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_grp_irq.sv
module gpio_grp_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic lvl_mode_i,
  input  logic val_zero_i,
  input  logic cause_wr_i,
  input  logic cause_zero_i,
  output logic irq_o
);
  logic irq_q, clr;

  assign clr = lvl_mode_i ? val_zero_i : (cause_wr_i & cause_zero_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    irq_q <= 1'b0;
    else if (set_i) irq_q <= 1'b1;  // set beats clear
    else if (clr)   irq_q <= 1'b0;
  end

  assign irq_o = irq_q;

  AST_IRQ_FROM_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(set_i)); // R6
  AST_LVL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_mode_i && val_zero_i && !set_i) |=> !irq_o); // R8
  AST_EDGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lvl_mode_i && !cause_wr_i && irq_o) |=> irq_o); // R7
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> irq_o); // R11
endmodule

// File: rtl/gpio_grp.sv
module gpio_grp
  import gpio_grp_pkg::*;
#(
  parameter int unsigned NUM_PINS   = 32,
  parameter int unsigned GRP_W      = 8,
  parameter int unsigned LVL_BIT    = 10,
  parameter logic [31:0] CTRL_FIXED = 32'h11ff0000
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       reg_we_i,
  input  logic [ADDR_W-1:0]          reg_addr_i,
  input  logic [31:0]                reg_wdata_i,
  output logic [31:0]                reg_rdata_o,
  input  logic [NUM_PINS-1:0]        pin_i,
  output logic [NUM_PINS-1:0]        pin_out_o,
  output logic [NUM_PINS-1:0]        pin_oe_o,
  output logic [NUM_PINS/GRP_W-1:0]  irq_grp_o
);
  localparam int unsigned NUM_GRP = NUM_PINS / GRP_W;

  logic [NUM_PINS-1:0] dir_q, pol_q, val_q, cause_q, mask_q;
  logic [NUM_PINS-1:0] val_d, cause_d, pin_s, cond, rise, wmask;
  logic                lvl_q;
  logic wr_dir, wr_pol, wr_val, wr_set, wr_clr, wr_cause, wr_mask, wr_ctrl;

  gpio_grp_sync #(.W(NUM_PINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  assign wr_dir   = reg_we_i && (reg_addr_i == A_DIR);
  assign wr_pol   = reg_we_i && (reg_addr_i == A_POL);
  assign wr_val   = reg_we_i && (reg_addr_i == A_VAL);
  assign wr_set   = reg_we_i && (reg_addr_i == A_SET);
  assign wr_clr   = reg_we_i && (reg_addr_i == A_CLR);
  assign wr_cause = reg_we_i && (reg_addr_i == A_CAUSE);
  assign wr_mask  = reg_we_i && ((reg_addr_i == A_MASK0) || (reg_addr_i == A_MASK1));
  assign wr_ctrl  = reg_we_i && (reg_addr_i == A_CTRL);

  assign wmask = reg_wdata_i[NUM_PINS-1:0] & dir_q;
  assign cond  = pin_s ^ pol_q;
  // value register holds last conditioned level of inputs: it is the edge history
  assign rise  = cond & ~val_q & ~dir_q;

  always_comb begin
    val_d = val_q;
    if (wr_val) val_d = (val_q & ~dir_q) | wmask;
    if (wr_set) val_d = val_q | wmask;
    if (wr_clr) val_d = val_q & ~wmask;
    val_d = (val_d & dir_q) | (cond & ~dir_q);
  end

  always_comb begin
    cause_d = wr_cause ? reg_wdata_i[NUM_PINS-1:0] : cause_q;
    cause_d = cause_d | rise;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q   <= '0;
      pol_q   <= '0;
      val_q   <= '0;
      cause_q <= '0;
      mask_q  <= '0;
      lvl_q   <= 1'b0;
    end else begin
      if (wr_dir)  dir_q  <= reg_wdata_i[NUM_PINS-1:0];
      if (wr_pol)  pol_q  <= reg_wdata_i[NUM_PINS-1:0];
      if (wr_mask) mask_q <= reg_wdata_i[NUM_PINS-1:0];
      if (wr_ctrl) lvl_q  <= reg_wdata_i[LVL_BIT];
      val_q   <= val_d;
      cause_q <= cause_d;
    end
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    gpio_grp_irq u_irq (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .set_i       (|(rise[g*GRP_W +: GRP_W] & mask_q[g*GRP_W +: GRP_W])),
      .lvl_mode_i  (lvl_q),
      .val_zero_i  (~|val_q[g*GRP_W +: GRP_W]),
      .cause_wr_i  (wr_cause),
      .cause_zero_i(~|reg_wdata_i[g*GRP_W +: GRP_W]),
      .irq_o       (irq_grp_o[g])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_DIR:            reg_rdata_o = 32'(dir_q);
      A_POL:            reg_rdata_o = 32'(pol_q);
      A_VAL:            reg_rdata_o = 32'(val_q);
      A_CAUSE:          reg_rdata_o = 32'(cause_q);
      A_MASK0, A_MASK1: reg_rdata_o = 32'(mask_q);
      A_CTRL:           reg_rdata_o = CTRL_FIXED | (32'(lvl_q) << LVL_BIT);
      default:          reg_rdata_o = '0;
    endcase
  end

  assign pin_out_o = val_q;
  assign pin_oe_o  = dir_q;

  AST_OUT_ONLY_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_val |=> ((val_q & $past(dir_q)) == ($past(reg_wdata_i[NUM_PINS-1:0]) & $past(dir_q)))); // R2
  AST_ALIAS_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((reg_addr_i == A_SET) || (reg_addr_i == A_CLR)) |-> (reg_rdata_o == 32'h0)); // R3
  AST_CAUSE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_cause |=> (($past(cause_q) & ~cause_q) == '0)); // R5
  AST_CTRL_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == A_CTRL) |-> (reg_rdata_o[31:16] == CTRL_FIXED[31:16])); // R9
endmodule

// File: tb/test_gpio_grp.sv
module test_gpio_grp;
  import gpio_grp_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, pout, poe;
  logic [31:0] pins = '0;
  logic [3:0]  irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  gpio_grp i_gpio_grp (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .pin_i(pins),
    .pin_out_o(pout), .pin_oe_o(poe), .irq_grp_o(irq)
  );

  typedef struct packed {
    logic        wr;
    logic [3:0]  adr;
    logic [31:0] dat;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'd0, 32'h0, 32'h00000000, 8'd1},   // R1 dir
    '{1'b0, 4'd1, 32'h0, 32'h00000000, 8'd1},   // R1 pol
    '{1'b0, 4'd2, 32'h0, 32'h00000000, 8'd1},   // R1 value
    '{1'b0, 4'd5, 32'h0, 32'h00000000, 8'd1},   // R1 cause
    '{1'b0, 4'd6, 32'h0, 32'h00000000, 8'd1},   // R1 mask
    '{1'b0, 4'd8, 32'h0, 32'h11ff0000, 8'd1},   // R1 ctrl
    '{1'b1, 4'd0, 32'h0000ffff, 32'h0, 8'd2},
    '{1'b1, 4'd2, 32'hffffffff, 32'h0, 8'd2},
    '{1'b0, 4'd2, 32'h0, 32'h0000ffff, 8'd2},   // R2
    '{1'b1, 4'd4, 32'h000000ff, 32'h0, 8'd3},
    '{1'b0, 4'd2, 32'h0, 32'h0000ff00, 8'd3},   // R3 clear
    '{1'b1, 4'd3, 32'hff0000f0, 32'h0, 8'd3},
    '{1'b0, 4'd2, 32'h0, 32'h0000fff0, 8'd3},   // R3 set masked
    '{1'b0, 4'd3, 32'h0, 32'h00000000, 8'd3},   // R3 alias reads 0
    '{1'b0, 4'd4, 32'h0, 32'h00000000, 8'd3},   // R3
    '{1'b1, 4'd6, 32'h12345678, 32'h0, 8'd10},
    '{1'b0, 4'd7, 32'h0, 32'h12345678, 8'd10},  // R10
    '{1'b1, 4'd7, 32'h0f0f0f0f, 32'h0, 8'd10},
    '{1'b0, 4'd6, 32'h0, 32'h0f0f0f0f, 8'd10},  // R10
    '{1'b1, 4'd8, 32'hffffffff, 32'h0, 8'd9},
    '{1'b0, 4'd8, 32'h0, 32'h11ff0400, 8'd9}    // R9
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic irq_chk(input string req, input logic [3:0] exp);
    @(negedge clk);
    #1 chk(req, 32'(irq), 32'(exp));
  endtask

  task automatic do_reset();
    @(negedge clk);
    pins = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  task automatic set_pins(input logic [31:0] p);
    @(negedge clk);
    pins = p;
    repeat (3) @(posedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    do_reset();
    irq_chk("R1 irq", 4'h0);
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) wr(VECS[i].adr, VECS[i].dat);
      else rd_chk($sformatf("R%0d table[%0d]", VECS[i].req, i), VECS[i].adr, VECS[i].exp);
    end

    // R4 R5 R6 R7 edge mode
    do_reset();
    wr(4'd6, 32'h000000ff);
    @(negedge clk); pins = 32'h8;
    repeat (2) @(posedge clk);
    rd_chk("R4 latency", 4'd2, 32'h0);
    @(posedge clk);
    rd_chk("R4 value", 4'd2, 32'h8);
    rd_chk("R5 cause", 4'd5, 32'h8);
    irq_chk("R6 grp0", 4'b0001);
    set_pins(32'h1008);
    rd_chk("R5 cause2", 4'd5, 32'h1008);
    irq_chk("R6 unmasked", 4'b0001);
    wr(4'd2, 32'h0);
    rd_chk("R2 inputs kept", 4'd2, 32'h1008);
    set_pins(32'h1000);
    rd_chk("R4 fall", 4'd2, 32'h1000);
    rd_chk("R5 sticky", 4'd5, 32'h1008);
    irq_chk("R7 no drop on fall", 4'b0001);
    wr(4'd6, 32'hffffffff);
    set_pins(32'h101000);
    irq_chk("R6 grp2", 4'b0101);
    rd_chk("R5 cause3", 4'd5, 32'h101008);
    wr(4'd5, 32'h101000);
    irq_chk("R7 grp0 cleared", 4'b0100);
    wr(4'd5, 32'h200000);
    irq_chk("R7 grp2 kept", 4'b0100);
    rd_chk("R7 cause", 4'd5, 32'h200000);
    wr(4'd5, 32'h0);
    irq_chk("R7 all clear", 4'b0000);

    // R4 polarity
    do_reset();
    wr(4'd1, 32'h00010000);
    @(posedge clk);
    rd_chk("R4 pol invert", 4'd2, 32'h00010000);
    set_pins(32'h00010000);
    rd_chk("R4 pol high", 4'd2, 32'h0);

    // R8 level mode
    do_reset();
    wr(4'd6, 32'hffffffff);
    wr(4'd8, 32'h00000400);
    set_pins(32'h600);
    irq_chk("R8 raise", 4'b0010);
    wr(4'd5, 32'h0);
    irq_chk("R8 cause write ignored", 4'b0010);
    set_pins(32'h400);
    irq_chk("R8 one bit left", 4'b0010);
    @(negedge clk); pins = 32'h0;
    repeat (3) @(posedge clk);
    irq_chk("R8 before drop", 4'b0010);
    @(posedge clk);
    irq_chk("R8 dropped", 4'b0000);

    // R11 same-edge rise and cause write
    do_reset();
    wr(4'd6, 32'hffffffff);
    set_pins(32'h2);
    irq_chk("R11 pre", 4'b0001);
    @(negedge clk); pins = 32'h3;
    repeat (2) @(posedge clk);
    wr(4'd5, 32'h0);
    rd_chk("R11 cause", 4'd5, 32'h1);
    irq_chk("R11 irq kept", 4'b0001);

    done = 1'b1;
    summary();
  end
endmodule